// File: doc/BRIEF.md
# Chained DMA Buffer Pause Controller

This block sequences a storage-interface DMA engine across a chain of memory buffers. One side reads words from a source buffer and the other writes words into a target buffer. Each side holds an active address and a remaining word count. When a side runs out, the block does one of two things, chosen by a per-side mode bit. It can copy the next base and size that software has already loaded into shadow registers, and keep moving. Or it can stop in a pause state, raise an interrupt and wait for a CONTINUE command.

The first boundary on each side after START always pauses. Hardware sets that side's mode bit to 1 at that boundary. This keeps the engine from walking the first buffer a second time before software has supplied a new one. Software may clear the bit again while paused, and later boundaries then reload on their own.

A third mode bit chooses what happens when the device ends an Ultra-DMA burst early: hold in pause, or carry on. Software drives the block through a word-wide register write port. The engine reports each transferred word through a one-cycle beat input per side.

Top module: `dma_chain_pause`

## Requirements
- R1: After reset, `cfg_word`, `int_status` and `irq` are zero, and `busy`, `paused`, `src_req` and `dst_req` are low.
- R2: The configuration word sits at offset 0 and is read back on `cfg_word`. Bit 9 is the early-termination auto mode, bit 8 is the source pause mode and bit 7 is the target pause mode. All other bits read as zero. A write at offset 0 is ignored while running and accepted in idle or pause.
- R3: A write at offset 5 with bit 0 set (START) has effect only in idle. It loads the source base and size (offsets 1, 2) and the target base and size (offsets 3, 4) into the active registers and starts running. Each side's address steps by WORD_BYTES per accepted beat. Its request output is high while running with a nonzero count.
- R4: On the source beat that takes the count to zero, `int_status` bit 0 is set. If the source mode (bit 8, after any forcing) is 0, the source shadow base and size are loaded on the same edge and the block keeps running. If it is 1, the block pauses.
- R5: The target side behaves the same way at the beat that fills it, with `int_status` bit 1 and configuration bit 7.
- R6: At the first boundary of each side after START, hardware sets that side's mode bit to 1 and the block pauses, whatever the programmed value.
- R7: An `early_term` pulse while running sets `int_status` bit 2. With bit 9 at 1 the block keeps running; with bit 9 at 0 it pauses.
- R8: In pause, beats are ignored and the active addresses do not move. A write at offset 5 with bit 1 set (CONTINUE) has effect only in pause. It reloads each side whose count is zero from its shadow registers and resumes running.
- R9: A write at offset 5 with bit 2 set (STOP) returns the block to idle from any state.
- R10: Writing 1s at offset 6 clears the matching `int_status` bits, and a new event on the same edge wins. `irq` is the registered OR of `int_status` masked by the enable bits at offset 7 (bits 2:0), and follows one cycle after the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 32 | Register write data |
| cfg_word | output | 32 | Configuration word readback |
| src_req | output | 1 | Source side may transfer a word |
| src_addr | output | ADDR_W | Current source word address |
| src_beat | input | 1 | One source word transferred |
| dst_req | output | 1 | Target side may transfer a word |
| dst_addr | output | ADDR_W | Current target word address |
| dst_beat | input | 1 | One target word transferred |
| early_term | input | 1 | Device ended an Ultra-DMA burst early |
| busy | output | 1 | Not idle |
| paused | output | 1 | In the pause state |
| int_status | output | 3 | Sticky events: source empty, target full, early termination |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that beats and `early_term` are single-cycle pulses. A beat that arrives without a request only counts as ignored. They also assume that software loads nonzero shadow sizes before any reload that is expected to run. The stimulus drives every pulse for exactly one cycle and programs sizes of one to three words. It sends beats in pause only on purpose, to show that they are ignored. Register writes land only in the states each scenario names, so cfg locking and the set-versus-clear ordering are both exercised.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSE} dcp_state_e;

  localparam logic [2:0] OFS_CFG      = 3'd0;
  localparam logic [2:0] OFS_SRC_BASE = 3'd1;
  localparam logic [2:0] OFS_SRC_SIZE = 3'd2;
  localparam logic [2:0] OFS_DST_BASE = 3'd3;
  localparam logic [2:0] OFS_DST_SIZE = 3'd4;
  localparam logic [2:0] OFS_CMD      = 3'd5;
  localparam logic [2:0] OFS_STATUS   = 3'd6;
  localparam logic [2:0] OFS_ENABLE   = 3'd7;

  localparam int BIT_UDMA_AUTO = 9;
  localparam int BIT_SRC_PAUSE = 8;
  localparam int BIT_DST_PAUSE = 7;

  localparam int CMD_START = 0;
  localparam int CMD_CONT  = 1;
  localparam int CMD_STOP  = 2;

  localparam int NUM_EVT = 3;
endpackage

// File: rtl/dcp_side.sv
module dcp_side #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic              start,
  input  logic              reload,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  size,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              req,
  output logic              bnd,
  output logic              first
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic take;

  assign req  = running && (cnt != '0);
  assign take = beat && req;
  assign bnd  = take && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cnt  <= '0;
    end else if (start || reload) begin
      addr <= base;
      cnt  <= size;
    end else if (take) begin
      addr <= addr + STEP;
      cnt  <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        first <= 1'b0;
    else if (start) first <= 1'b1;
    else if (bnd)   first <= 1'b0;
  end

  // R3: a count at zero never moves on a beat unless reloaded
  assert_cnt_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !start && !reload) |=> (cnt == '0 || $past(start) || $past(reload)));
endmodule

// File: rtl/dcp_irq.sv
module dcp_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic         en_we,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] enable;
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_mask) | set;
      if (en_we) enable <= en_data;
      irq <= |(status & enable);
    end
  end

  // R10: status bits are sticky unless cleared by a write
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/dma_chain_pause.sv
module dma_chain_pause
  import dcp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       cfg_word,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_beat,
  output logic              dst_req,
  output logic [ADDR_W-1:0] dst_addr,
  input  logic              dst_beat,
  input  logic              early_term,
  output logic              busy,
  output logic              paused,
  output logic [2:0]        int_status,
  output logic              irq
);
  localparam int NSIDE = 2;  // index 0 = source, 1 = target

  dcp_state_e state, state_nxt;

  logic              udma_auto;
  logic [NSIDE-1:0]  side_pause;
  logic [ADDR_W-1:0] sh_base [NSIDE];
  logic [CNT_W-1:0]  sh_size [NSIDE];
  logic [ADDR_W-1:0] act_addr [NSIDE];
  logic [CNT_W-1:0]  act_cnt [NSIDE];
  logic [NSIDE-1:0]  beat_in, req_o, bnd, first, mode_eff, reload, halt_side;

  logic wr_cfg, wr_cmd, start_cmd, cont_cmd, stop_cmd, running, et_evt, et_halt;

  assign running   = (state == ST_RUN);
  assign wr_cfg    = wr_en && (wr_addr == OFS_CFG);
  assign wr_cmd    = wr_en && (wr_addr == OFS_CMD);
  assign start_cmd = wr_cmd && wr_data[CMD_START] && (state == ST_IDLE);
  assign cont_cmd  = wr_cmd && wr_data[CMD_CONT] && (state == ST_PAUSE);
  assign stop_cmd  = wr_cmd && wr_data[CMD_STOP];
  assign et_evt    = early_term && running;
  assign et_halt   = et_evt && !udma_auto;
  assign beat_in   = {dst_beat, src_beat};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_base[0] <= '0; sh_size[0] <= '0;
      sh_base[1] <= '0; sh_size[1] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_SRC_BASE: sh_base[0] <= wr_data[ADDR_W-1:0];
        OFS_SRC_SIZE: sh_size[0] <= wr_data[CNT_W-1:0];
        OFS_DST_BASE: sh_base[1] <= wr_data[ADDR_W-1:0];
        OFS_DST_SIZE: sh_size[1] <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    assign mode_eff[g]  = side_pause[g] | first[g];
    assign halt_side[g] = bnd[g] & mode_eff[g];
    assign reload[g]    = (bnd[g] & ~mode_eff[g]) | (cont_cmd & (act_cnt[g] == '0));

    dcp_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_side (
      .clk(clk), .rst(rst), .running(running), .start(start_cmd), .reload(reload[g]),
      .base(sh_base[g]), .size(sh_size[g]), .beat(beat_in[g]),
      .addr(act_addr[g]), .cnt(act_cnt[g]), .req(req_o[g]), .bnd(bnd[g]), .first(first[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      udma_auto  <= 1'b0;
      side_pause <= '0;
    end else if (wr_cfg && !running) begin
      udma_auto     <= wr_data[BIT_UDMA_AUTO];
      side_pause[0] <= wr_data[BIT_SRC_PAUSE];
      side_pause[1] <= wr_data[BIT_DST_PAUSE];
    end else begin
      for (int i = 0; i < NSIDE; i++)
        if (bnd[i] && first[i]) side_pause[i] <= 1'b1;
    end
  end

  always_comb begin
    state_nxt = state;
    if (stop_cmd)                                       state_nxt = ST_IDLE;
    else if (start_cmd)                                 state_nxt = ST_RUN;
    else if (running && ((|halt_side) || et_halt))      state_nxt = ST_PAUSE;
    else if (cont_cmd)                                  state_nxt = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  dcp_irq #(.N(NUM_EVT)) u_irq (
    .clk(clk), .rst(rst), .set({et_evt, bnd[1], bnd[0]}),
    .clr_we(wr_en && (wr_addr == OFS_STATUS)), .clr_data(wr_data[NUM_EVT-1:0]),
    .en_we(wr_en && (wr_addr == OFS_ENABLE)), .en_data(wr_data[NUM_EVT-1:0]),
    .status(int_status), .irq(irq)
  );

  assign cfg_word = {22'b0, udma_auto, side_pause[0], side_pause[1], 7'b0};
  assign src_req  = req_o[0];
  assign dst_req  = req_o[1];
  assign src_addr = act_addr[0];
  assign dst_addr = act_addr[1];
  assign busy     = (state != ST_IDLE);
  assign paused   = (state == ST_PAUSE);

  // R6: first boundary on a side always ends in pause with its mode bit set
  assert_first_pause_R6: assert property (@(posedge clk) disable iff (rst)
    (bnd[0] && first[0] && !stop_cmd) |=> (paused && cfg_word[BIT_SRC_PAUSE]));
  assert_first_pause_dst_R6: assert property (@(posedge clk) disable iff (rst)
    (bnd[1] && first[1] && !stop_cmd) |=> (paused && cfg_word[BIT_DST_PAUSE]));
  // R2: configuration writes while running leave the word unchanged
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (running && wr_cfg && !(|bnd)) |=> $stable(cfg_word));
  // R8: nothing moves the active addresses while paused
  assert_pause_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (paused && !cont_cmd && !stop_cmd) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

// File: tb/dma_chain_pause_bench.sv
`timescale 1ns/1ps
module dma_chain_pause_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cfg_word;
  logic        src_req, dst_req, src_beat = 1'b0, dst_beat = 1'b0, early_term = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic        busy, paused, irq;
  logic [2:0]  int_status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] src_q[$];
  logic [31:0] dst_q[$];

  always #2 clk = ~clk;

  dma_chain_pause u_dma_chain_pause (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_word(cfg_word), .src_req(src_req), .src_addr(src_addr), .src_beat(src_beat),
    .dst_req(dst_req), .dst_addr(dst_addr), .dst_beat(dst_beat), .early_term(early_term),
    .busy(busy), .paused(paused), .int_status(int_status), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sbeat(logic [31:0] exp_addr);
    src_q.push_back(exp_addr);
    @(negedge clk); src_beat = 1'b1;
    @(negedge clk); src_beat = 1'b0;
  endtask

  task automatic sbeat_ignored();
    @(negedge clk); src_beat = 1'b1;
    @(negedge clk); src_beat = 1'b0;
  endtask

  task automatic dbeat(logic [31:0] exp_addr);
    dst_q.push_back(exp_addr);
    @(negedge clk); dst_beat = 1'b1;
    @(negedge clk); dst_beat = 1'b0;
  endtask

  task automatic eterm();
    @(negedge clk); early_term = 1'b1;
    @(negedge clk); early_term = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: each accepted beat must match the next expected address (R3, R4, R5)
  always @(posedge clk) begin
    if (!rst && src_beat && src_req) begin
      if (src_q.size() == 0) chk("R3 unexpected source beat", src_addr, 32'hFFFF_FFFF);
      else chk("R3 source beat address", src_addr, src_q.pop_front());
    end
    if (!rst && dst_beat && dst_req) begin
      if (dst_q.size() == 0) chk("R5 unexpected target beat", dst_addr, 32'hFFFF_FFFF);
      else chk("R5 target beat address", dst_addr, dst_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_word", cfg_word, 0);
    chk("R1 busy/paused", {busy, paused}, 0);
    chk("R1 requests", {src_req, dst_req}, 0);
    chk("R1 status/irq", {int_status, irq}, 0);

    // R2 field positions and zero bits
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R2 cfg readback", cfg_word, 32'h0000_0380);
    wr(3'd0, 32'h0);
    chk("R2 cfg cleared in idle", cfg_word, 0);

    // R3 start
    wr(3'd1, 32'h1000); wr(3'd2, 3);
    wr(3'd3, 32'h2000); wr(3'd4, 2);
    wr(3'd7, 7);
    wr(3'd5, 1);
    chk("R3 running after START", {busy, paused, src_req, dst_req}, 4'b1011);
    chk("R3 source base loaded", src_addr, 32'h1000);

    // R5 + R6 first target boundary pauses and forces bit 7
    dbeat(32'h2000); dbeat(32'h2004);
    chk("R6 paused after first target fill", paused, 1);
    chk("R6 target mode forced", cfg_word, 32'h80);
    chk("R5 target full status", int_status, 3'b010);
    chk("R10 irq not yet", irq, 0);
    @(negedge clk);
    chk("R10 irq one cycle later", irq, 1);

    // R8 beats ignored in pause
    chk("R8 no request in pause", {src_req, dst_req}, 0);
    sbeat_ignored();
    chk("R8 source address held in pause", src_addr, 32'h1000);

    // R2 writable in pause; R8 CONTINUE reloads only the empty side
    wr(3'd0, 32'h0);
    chk("R2 cfg written in pause", cfg_word, 0);
    wr(3'd3, 32'h3000); wr(3'd4, 2);
    wr(3'd5, 2);
    chk("R8 running after CONTINUE", {busy, paused}, 2'b10);
    chk("R8 target reloaded", dst_addr, 32'h3000);
    chk("R8 source not reloaded", src_addr, 32'h1000);

    // R6 first source boundary forces pause although bit 8 was 0
    sbeat(32'h1000); sbeat(32'h1004); sbeat(32'h1008);
    chk("R6 paused after first source empty", paused, 1);
    chk("R6 source mode forced", cfg_word, 32'h100);
    chk("R4 source empty status", int_status, 3'b011);

    // R10 write-1-to-clear and irq drop
    wr(3'd6, 3);
    chk("R10 status cleared", int_status, 0);
    @(negedge clk);
    chk("R10 irq dropped", irq, 0);

    // R4 auto reload on later source boundary
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h5000); wr(3'd2, 1);
    wr(3'd5, 2);
    chk("R8 source reloaded on CONTINUE", src_addr, 32'h5000);
    wr(3'd1, 32'h6000); wr(3'd2, 2);
    sbeat(32'h5000);
    chk("R4 still running after auto reload", {busy, paused}, 2'b10);
    chk("R4 source auto reloaded", src_addr, 32'h6000);
    chk("R4 empty status on auto reload", int_status, 3'b001);

    // R5 auto reload on later target boundary
    dbeat(32'h3000); dbeat(32'h3004);
    chk("R5 still running after auto reload", paused, 0);
    chk("R5 target auto reloaded", dst_addr, 32'h3000);
    chk("R5 full status on auto reload", int_status, 3'b011);

    // R2 cfg write ignored while running
    wr(3'd0, 32'h200);
    chk("R2 cfg write ignored while running", cfg_word, 0);

    // R7 early termination pauses with bit 9 at 0
    wr(3'd6, 7);
    eterm();
    chk("R7 paused on early termination", paused, 1);
    chk("R7 early termination status", int_status, 3'b100);

    // R7 auto continue with bit 9 at 1
    wr(3'd0, 32'h200);
    chk("R2 auto bit written in pause", cfg_word, 32'h200);
    wr(3'd5, 2);
    chk("R8 no reload of nonempty source", src_addr, 32'h6000);
    wr(3'd6, 7);
    eterm();
    chk("R7 keeps running with auto bit", {busy, paused}, 2'b10);
    chk("R7 status set with auto bit", int_status, 3'b100);

    // R8 CONTINUE ignored while running
    wr(3'd5, 2);
    chk("R8 CONTINUE ignored when running", {paused, src_addr}, {1'b0, 32'h6000});

    // R9 STOP
    wr(3'd5, 4);
    chk("R9 idle after STOP", {busy, src_req, dst_req}, 0);

    chk("R3 source queue drained", src_q.size(), 0);
    chk("R5 target queue drained", dst_q.size(), 0);
    finish_run();
  end
endmodule